// File: doc/BRIEF.md
# Automata Counter Element

This block is a programmable event counter that sits among the state elements of a hardware automaton. It builds bounded repetition (a quantifier that needs at least or at most a given number of matches) and path pruning (letting a cycle in the automaton be walked only once). A mask picks which routing lines may advance the count, and a separate index picks the one routing line that clears it. An active-low asynchronous reset overrides everything.

The count is made of 12-bit stages. A configuration input chains one to four of them into a single counter of up to 48 bits. When the count reaches the programmed target, the single activation output reacts according to the output mode. In pulse mode it fires once and then lies dormant. In hold mode it stays on until a reset. In reload mode it fires and restarts from zero, so it repeats every target-count events. The output is registered: it changes in the cycle after the clock edge that takes in the reaching count.

Top module: `automata_counter`

## Requirements
- R1: On each clock edge where at least one count line selected by a 1 in `cnt_sel_i` is high, and the counter is neither dormant nor being reset, the count rises by exactly one. Lines whose mask bit is 0 have no effect.
- R2: `act_o` is registered. It can only rise after a clock edge that took in a count, and it rises after the edge at which the count becomes equal to the target.
- R3: `stages_i` sets how many 12-bit stages are chained (1 to 4, with 0 treated as 1). Stage k+1 advances only on the carry out of stage k. The target compare covers only the chained stages, so target bits above them are ignored.
- R4: Pulse mode (`mode_i` = 2'b00, and also 2'b11) drives `act_o` high for exactly one cycle. Counting then freezes, and further count lines cannot raise the output again until a reset. With a target of 1 this gives a one-shot.
- R5: Hold mode (`mode_i` = 2'b01) keeps `act_o` high from the moment the target is reached until a reset.
- R6: Reload mode (`mode_i` = 2'b10) drives `act_o` high for one cycle when the target is reached and returns the count to zero on that same edge. The next event follows after another full target of counts.
- R7: A high level on `rst_in_i[rst_sel_i]` at a clock edge clears the count, the dormant flag and `act_o`. It wins over a count arriving at the same edge. Reset lines other than the selected one have no effect.
- R8: A low level on `rst_ni` clears the count and `act_o` at once, without waiting for a clock edge. Counting resumes from zero after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous overriding reset, active low |
| cnt_in_i | input | N_CNT_IN | Routing lines that may advance the count |
| cnt_sel_i | input | N_CNT_IN | Mask of the count lines that take part |
| rst_in_i | input | N_RST_IN | Routing lines that may clear the counter |
| rst_sel_i | input | RSEL_W | Index of the reset line in use |
| stages_i | input | STG_W | Number of chained 12-bit stages |
| target_i | input | STAGE_W*N_STAGES | Target count, least significant stage in the low bits |
| mode_i | input | 2 | Output mode: 00 pulse, 01 hold, 10 reload, 11 pulse |
| act_o | output | 1 | Activation line back to the automaton |

## Verification
Two functions can land on the same edge: the synchronous clear and a count that would reach or approach the target. The bench raises the selected reset line in the same cycle as a count line, after two counts toward a target of three. It then shows that the count really went back to zero: two further counts leave `act_o` low, and only a third raises it. A second collision is checked by assertion: in hold mode the output must stay high unless the clear is present, and any edge with the clear must leave the output low.

// File: rtl/acnt_pkg.sv
package acnt_pkg;
  typedef enum logic [1:0] {
    MODE_PULSE     = 2'b00,
    MODE_HOLD      = 2'b01,
    MODE_RELOAD    = 2'b10,
    MODE_PULSE_ALT = 2'b11
  } acnt_mode_e;
endpackage

// File: rtl/acnt_input_sel.sv
module acnt_input_sel #(
  parameter int N_CNT_IN = 4,
  parameter int N_RST_IN = 4,
  localparam int RSEL_W  = (N_RST_IN > 1) ? $clog2(N_RST_IN) : 1
) (
  input  logic [N_CNT_IN-1:0] cnt_in_i,
  input  logic [N_CNT_IN-1:0] cnt_sel_i,
  input  logic [N_RST_IN-1:0] rst_in_i,
  input  logic [RSEL_W-1:0]   rst_sel_i,
  output logic                cnt_en_o,
  output logic                sync_rst_o
);
  assign cnt_en_o = |(cnt_in_i & cnt_sel_i);

  always_comb begin
    sync_rst_o = 1'b0;
    for (int i = 0; i < N_RST_IN; i++) begin
      if (int'(rst_sel_i) == i) sync_rst_o = rst_in_i[i];
    end
  end
endmodule

// File: rtl/acnt_stage.sv
module acnt_stage #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] cnt_q;

  assign nxt_o = inc_i ? cnt_q + W'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= nxt_o;
  end
endmodule

// File: rtl/acnt_match.sv
module acnt_match #(
  parameter int STAGE_W  = 12,
  parameter int N_STAGES = 4
) (
  input  logic [N_STAGES-1:0][STAGE_W-1:0] val_i,
  input  logic [N_STAGES-1:0][STAGE_W-1:0] tgt_i,
  input  logic [N_STAGES-1:0]              active_i,
  output logic                             eq_o
);
  logic [N_STAGES-1:0] stage_eq;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_cmp
    assign stage_eq[k] = !active_i[k] || (val_i[k] == tgt_i[k]);
  end

  assign eq_o = &stage_eq;
endmodule

// File: rtl/automata_counter.sv
module automata_counter
  import acnt_pkg::*;
#(
  parameter int STAGE_W  = 12,
  parameter int N_STAGES = 4,
  parameter int N_CNT_IN = 4,
  parameter int N_RST_IN = 4,
  localparam int TGT_W   = STAGE_W * N_STAGES,
  localparam int RSEL_W  = (N_RST_IN > 1) ? $clog2(N_RST_IN) : 1,
  localparam int STG_W   = $clog2(N_STAGES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_CNT_IN-1:0] cnt_in_i,
  input  logic [N_CNT_IN-1:0] cnt_sel_i,
  input  logic [N_RST_IN-1:0] rst_in_i,
  input  logic [RSEL_W-1:0]   rst_sel_i,
  input  logic [STG_W-1:0]    stages_i,
  input  logic [TGT_W-1:0]    target_i,
  input  logic [1:0]          mode_i,
  output logic                act_o
);
  acnt_mode_e mode;
  logic cnt_en, sync_rst, inc, eq, hit, reload_hit;
  logic fired_q, act_q;
  logic [N_STAGES-1:0]              active, carry_in, stage_clr;
  logic [N_STAGES-1:0][STAGE_W-1:0] nxt, tgt;

  assign mode = acnt_mode_e'(mode_i);
  assign tgt  = target_i;

  acnt_input_sel #(.N_CNT_IN(N_CNT_IN), .N_RST_IN(N_RST_IN)) u_sel (
    .cnt_in_i  (cnt_in_i),
    .cnt_sel_i (cnt_sel_i),
    .rst_in_i  (rst_in_i),
    .rst_sel_i (rst_sel_i),
    .cnt_en_o  (cnt_en),
    .sync_rst_o(sync_rst)
  );

  // dormant after a pulse or hold event
  assign inc        = cnt_en && !fired_q;
  assign hit        = inc && !sync_rst && eq;
  assign reload_hit = hit && (mode == MODE_RELOAD);

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_lsb
      assign active[k]   = 1'b1;
      assign carry_in[k] = inc;
    end else begin : g_upper
      assign active[k]   = (k < int'(stages_i));
      // next value wrapped to zero under a carry means this stage overflowed
      assign carry_in[k] = carry_in[k-1] && (nxt[k-1] == '0) && active[k];
    end
    assign stage_clr[k] = sync_rst || reload_hit || !active[k];

    acnt_stage #(.W(STAGE_W)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (stage_clr[k]),
      .inc_i (carry_in[k]),
      .nxt_o (nxt[k])
    );
  end

  acnt_match #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_match (
    .val_i   (nxt),
    .tgt_i   (tgt),
    .active_i(active),
    .eq_o    (eq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      act_q   <= 1'b0;
    end else if (sync_rst) begin
      fired_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      fired_q <= fired_q || (hit && (mode != MODE_RELOAD));
      act_q   <= hit || ((mode == MODE_HOLD) && act_q);
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/automata_counter_chk.sv
module automata_counter_chk
  import acnt_pkg::*;
#(
  parameter int N_CNT_IN = 4,
  parameter int N_RST_IN = 4,
  localparam int RSEL_W  = (N_RST_IN > 1) ? $clog2(N_RST_IN) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_CNT_IN-1:0] cnt_in_i,
  input logic [N_CNT_IN-1:0] cnt_sel_i,
  input logic [N_RST_IN-1:0] rst_in_i,
  input logic [RSEL_W-1:0]   rst_sel_i,
  input logic [1:0]          mode_i,
  input logic                act_o
);
  logic cnt_seen, clr_seen;
  assign cnt_seen = |(cnt_in_i & cnt_sel_i);
  always_comb begin
    clr_seen = 1'b0;
    for (int i = 0; i < N_RST_IN; i++) if (int'(rst_sel_i) == i) clr_seen = rst_in_i[i];
  end

  a_r7_clear_drops_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_seen |=> !act_o);

  a_r2_rise_needs_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_seen |=> !$rose(act_o));

  a_r4_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && mode_i[0] == mode_i[1] && $past(mode_i) == mode_i) |=> !act_o);

  a_r5_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && mode_i == 2'b01 && !clr_seen) |=> act_o);
endmodule

bind automata_counter automata_counter_chk #(.N_CNT_IN(N_CNT_IN), .N_RST_IN(N_RST_IN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_in_i (cnt_in_i),
  .cnt_sel_i(cnt_sel_i),
  .rst_in_i (rst_in_i),
  .rst_sel_i(rst_sel_i),
  .mode_i   (mode_i),
  .act_o    (act_o)
);

// File: tb/tb_automata_counter.sv
`timescale 1ns/1ps
module tb_automata_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cnt_in = '0, cnt_sel = 4'hF, rst_in = '0;
  logic [1:0]  rst_sel = '0, mode = '0;
  logic [2:0]  stages = 3'd1;
  logic [47:0] target = 48'd3;
  logic        act;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  automata_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_in_i(cnt_in), .cnt_sel_i(cnt_sel),
    .rst_in_i(rst_in), .rst_sel_i(rst_sel), .stages_i(stages),
    .target_i(target), .mode_i(mode), .act_o(act)
  );

  // {mode, expected act, pad, target, count events}
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {2'b00, 1'b0, 5'd0, 12'd3, 12'd2},
    {2'b00, 1'b1, 5'd0, 12'd3, 12'd3},
    {2'b00, 1'b0, 5'd0, 12'd3, 12'd5},
    {2'b01, 1'b1, 5'd0, 12'd3, 12'd3},
    {2'b01, 1'b1, 5'd0, 12'd3, 12'd6},
    {2'b01, 1'b0, 5'd0, 12'd4, 12'd3},
    {2'b10, 1'b1, 5'd0, 12'd3, 12'd3},
    {2'b10, 1'b0, 5'd0, 12'd3, 12'd4},
    {2'b10, 1'b1, 5'd0, 12'd3, 12'd6},
    {2'b00, 1'b1, 5'd0, 12'd1, 12'd1},
    {2'b11, 1'b1, 5'd0, 12'd2, 12'd2}
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: act_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // n count events on line b; returns at the negedge after the last edge
  task automatic count_n(input int n, input int b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_in = 4'b1 << b;
    end
    @(negedge clk); cnt_in = '0;
  endtask

  task automatic sreset();
    @(negedge clk); rst_in[rst_sel] = 1'b1;
    @(negedge clk); rst_in = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, act_o=%b expected completion", act);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset state", act, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      mode   = VEC[v][31:30];
      target = 48'(VEC[v][23:12]);
      sreset();
      count_n(int'(VEC[v][11:0]), v % 4);
      check(mode == 2'b01 ? "R5 hold vector" : mode == 2'b10 ? "R6 reload vector" : "R4 pulse vector",
            act, VEC[v][29]);
    end

    // R4 dormant after pulse, rearmed by reset
    begin
      bit stray = 0;
      mode = 2'b00; target = 48'd2; sreset();
      count_n(2, 0); check("R4 pulse fires", act, 1'b1);
      for (int i = 0; i < 10; i++) begin count_n(1, 1); if (act) stray = 1; end
      check("R4 dormant after pulse", stray, 1'b0);
      sreset(); count_n(2, 2); check("R4 rearm after reset", act, 1'b1);
    end

    // R6 reload repeats from zero
    mode = 2'b10; target = 48'd4; sreset();
    count_n(4, 0); check("R6 first reload event", act, 1'b1);
    count_n(3, 0); check("R6 no early event", act, 1'b0);
    count_n(1, 0); check("R6 second reload event", act, 1'b1);

    // R7 reset wins over a coincident count
    mode = 2'b00; target = 48'd3; sreset();
    count_n(2, 0);
    @(negedge clk); cnt_in = 4'b0001; rst_in[0] = 1'b1;
    @(negedge clk); cnt_in = '0; rst_in = '0;
    check("R7 clear with count", act, 1'b0);
    count_n(2, 0); check("R7 count restarted at zero", act, 1'b0);
    count_n(1, 0); check("R7 target after restart", act, 1'b1);

    // R1 masked lines ignored
    cnt_sel = 4'b1101; mode = 2'b01; target = 48'd1; sreset();
    count_n(5, 1); check("R1 masked line ignored", act, 1'b0);
    count_n(1, 0); check("R1 selected line counts", act, 1'b1);
    cnt_sel = 4'hF;

    // R7 unselected reset ignored, selected one clears (hold is high here)
    @(negedge clk); rst_in = 4'b0100;
    @(negedge clk); rst_in = '0;
    check("R7 unselected reset ignored", act, 1'b1);
    rst_sel = 2'd2; sreset(); check("R7 selected reset index 2", act, 1'b0);
    rst_sel = 2'd0;

    // R8 asynchronous reset mid-run
    mode = 2'b01; target = 48'd3; sreset();
    count_n(3, 0); check("R5 hold before async reset", act, 1'b1);
    @(negedge clk); #2 rst_n = 1'b0; #1;
    check("R8 async clear immediate", act, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    count_n(2, 0); check("R8 count cleared", act, 1'b0);
    count_n(1, 0); check("R8 counts after release", act, 1'b1);

    // R3 cascade across two stages
    mode = 2'b01; stages = 3'd2; target = 48'd4099; sreset();
    count_n(4098, 3); check("R3 cascade one short", act, 1'b0);
    count_n(1, 3); check("R3 cascade carry reaches target", act, 1'b1);

    // R3 single stage ignores upper target bits
    stages = 3'd1; target = 48'h0000_0000_1005; sreset();
    count_n(4, 0); check("R3 upper bits ignored, short", act, 1'b0);
    count_n(1, 0); check("R3 upper bits ignored, hit", act, 1'b1);

    // R2 output waits for the edge that counts
    mode = 2'b00; target = 48'd2; sreset();
    @(negedge clk); cnt_in = 4'b0001;
    @(negedge clk); cnt_in = 4'b0001;
    check("R2 no output before edge", act, 1'b0);
    @(negedge clk); cnt_in = '0;
    check("R2 output after reaching edge", act, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule